// File: doc/BRIEF.md
# Reversible Up/Down LFSR Counter

This block is a maximal-length linear feedback shift register counter that can walk its sequence in either direction. On a forward step the register moves toward bit 0 and a parity bit computed from a forward tap set enters at the top. On a reverse step the register moves toward the top bit and a second parity, taken over a tap set offset by one position, enters at bit 0. That bit is exactly the one the matching forward step discarded, so a reverse step undoes a forward step. A parallel load places any value in the register. An XNOR-feedback variant uses the same tap positions in both directions.

The next state is picked by a small per-cycle operation decode with four named operations. OP_LOAD is chosen whenever `load` is high. OP_FWD is chosen when `en` and `up` are high. OP_REV is chosen when `en` is high and `up` is low. OP_HOLD covers every other case. Each bit has a stage multiplexer that picks its neighbour above (OP_FWD), its neighbour below (OP_REV), its load bit (OP_LOAD) or its own value (OP_HOLD). The only register is the state, and synchronous reset takes it to a nonzero seed. The reachable transitions are state to forward successor, state to reverse predecessor, state to loaded value, state to itself, and any state to the seed on reset.

Top module: `rlfsr_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, the state becomes SEED: 16'h0001 by default, or 16'h0000 in the XNOR build.
- R2: When both `load` and `en` are low, the state holds at any value of `up`.
- R3: When `load` is high, the next state equals `load_value`, whatever the values of `en` and `up`.
- R4: On a forward step (`en`=1, `up`=1, `load`=0), bits [14:0] take the old bits [15:1], and bit 15 becomes the XOR of old bits 12, 3, 1 and 0.
- R5: On a reverse step (`en`=1, `up`=0, `load`=0), bits [15:1] take the old bits [14:0], and bit 0 becomes the XOR of old bits 15, 11, 2 and 0.
- R6: A forward step followed at once by a reverse step returns the state to its value before the forward step.
- R7: Forward stepping from 16'h0001 returns to 16'h0001 after exactly 65535 steps and not sooner. Every step matches R4.
- R8: Reverse stepping from 16'h0001 also has period 65535. Every step matches R5.
- R9: In XOR mode, 16'h0000 is the lock-up state. A loaded 16'h0000 stays 16'h0000 under stepping, and a nonzero state never steps to 16'h0000.
- R10: With USE_XNOR=1, each feedback bit is the inverse of the R4/R5 parity over the same tap positions, and 16'hFFFF is the state that stays fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads SEED |
| en | input | 1 | Step enable |
| up | input | 1 | Direction: 1 forward, 0 reverse |
| load | input | 1 | Parallel load; takes priority over stepping |
| load_value | input | WIDTH | Value written on load |
| state | output | WIDTH | Current register contents |

## Verification
The bench builds two copies of the block. Both use WIDTH=16 and forward taps 16'h100B. One uses XOR feedback and seed 16'h0001. The other uses XNOR feedback and seed 16'h0000. At the default width, a full traversal takes 65535 steps, so complete sweeps in both directions are reachable in the run. Those sweeps compare every step against an independent model and show the period is maximal. The XNOR copy covers the inverted feedback and its all-ones fixed point. The XOR copy covers the all-zero lock-up.

// File: rtl/rlfsr_pkg.sv
package rlfsr_pkg;

    // Per-cycle operation chosen for the whole register.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_FWD  = 2'd1,
        OP_REV  = 2'd2,
        OP_LOAD = 2'd3
    } step_op_e;

    // Tap mask for the reverse parity. It always includes the top bit,
    // which holds the last forward parity. Each forward tap above bit 0
    // appears again one position lower, where it now sits after the shift.
    function automatic logic [63:0] reverse_taps(input logic [63:0] fwd, input int w);
        logic [63:0] r;
        r = '0;
        r[w-1] = 1'b1;
        for (int i = 1; i < 64; i++) begin
            if (i < w && fwd[i]) begin
                r[i-1] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rlfsr_op_decode.sv
module rlfsr_op_decode
    import rlfsr_pkg::*;
(
    input  logic     en,
    input  logic     up,
    input  logic     load,
    output step_op_e op
);

    // Load wins over stepping; direction only matters while enabled.
    always_comb begin
        op = OP_HOLD;
        unique casez ({load, en, up})
            3'b1??:  op = OP_LOAD;
            3'b011:  op = OP_FWD;
            3'b010:  op = OP_REV;
            3'b00?:  op = OP_HOLD;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/rlfsr_tap_xor.sv
module rlfsr_tap_xor #(
    parameter int              WIDTH  = 16,
    parameter logic [WIDTH-1:0] TAPS  = '1,
    parameter bit              INVERT = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    output logic             fb
);

    logic parity;

    assign parity = ^(cur & TAPS);

    generate
        if (INVERT) begin : g_xnor
            assign fb = ~parity;
        end else begin : g_xor
            assign fb = parity;
        end
    endgenerate

endmodule

// File: rtl/rlfsr_stage.sv
module rlfsr_stage
    import rlfsr_pkg::*;
(
    input  step_op_e op,
    input  logic     cur_bit,
    input  logic     fwd_src,
    input  logic     rev_src,
    input  logic     load_bit,
    output logic     nxt_bit
);

    always_comb begin
        nxt_bit = cur_bit;
        unique case (op)
            OP_HOLD: nxt_bit = cur_bit;
            OP_FWD:  nxt_bit = fwd_src;
            OP_REV:  nxt_bit = rev_src;
            OP_LOAD: nxt_bit = load_bit;
            default: nxt_bit = cur_bit;
        endcase
    end

endmodule

// File: rtl/rlfsr_counter.sv
module rlfsr_counter
    import rlfsr_pkg::*;
#(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] FWD_TAPS = 16'h100B,
    parameter bit               USE_XNOR = 1'b0,
    parameter logic [WIDTH-1:0] SEED     = 16'h0001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             up,
    input  logic             load,
    input  logic [WIDTH-1:0] load_value,
    output logic [WIDTH-1:0] state
);

    localparam logic [WIDTH-1:0] REV_TAPS = WIDTH'(reverse_taps(64'(FWD_TAPS), WIDTH));
    localparam logic [WIDTH-1:0] LOCK     = USE_XNOR ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    step_op_e         op;
    logic             fwd_fb;
    logic             rev_fb;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    rlfsr_op_decode u_decode (
        .en   (en),
        .up   (up),
        .load (load),
        .op   (op)
    );

    rlfsr_tap_xor #(.WIDTH(WIDTH), .TAPS(FWD_TAPS), .INVERT(USE_XNOR)) u_fwd_fb (
        .cur (state_q),
        .fb  (fwd_fb)
    );

    rlfsr_tap_xor #(.WIDTH(WIDTH), .TAPS(REV_TAPS), .INVERT(USE_XNOR)) u_rev_fb (
        .cur (state_q),
        .fb  (rev_fb)
    );

    // One stage multiplexer per bit. The end bits take a feedback
    // parity in place of the neighbour that is missing.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic from_hi;
            logic from_lo;
            if (i == WIDTH - 1) begin : g_hi_end
                assign from_hi = fwd_fb;
            end else begin : g_hi_mid
                assign from_hi = state_q[i+1];
            end
            if (i == 0) begin : g_lo_end
                assign from_lo = rev_fb;
            end else begin : g_lo_mid
                assign from_lo = state_q[i-1];
            end
            rlfsr_stage u_stage (
                .op       (op),
                .cur_bit  (state_q[i]),
                .fwd_src  (from_hi),
                .rev_src  (from_lo),
                .load_bit (load_value[i]),
                .nxt_bit  (state_d[i])
            );
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    assign state = state_q;

    AST_RESET_SEED: assert property (@(posedge clk) rst |=> state_q == SEED); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> state_q == $past(state_q)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> state_q == $past(load_value)); // R3

    AST_FWD_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (en && up && !load) |=> (state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1]))
            && (state_q[WIDTH-1] == ($past(^(state_q & FWD_TAPS)) ^ USE_XNOR))); // R4

    AST_REV_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (en && !up && !load) |=> (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]))
            && (state_q[0] == ($past(^(state_q & REV_TAPS)) ^ USE_XNOR))); // R5

    AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
        (en && up && !load) ##1 (en && !up && !load) |=> state_q == $past(state_q, 2)); // R6

    AST_NO_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!load && state_q != LOCK) |=> state_q != LOCK); // R9

    AST_LOCK_STUCK: assert property (@(posedge clk) disable iff (rst)
        (!load && state_q == LOCK) |=> state_q == LOCK); // R9 R10

endmodule

// File: tb/tb_rlfsr_counter.sv
`timescale 1ns/1ps
module tb_rlfsr_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        up = 1'b1;
    logic        load = 1'b0;
    logic [15:0] load_value = '0;
    logic [15:0] st;
    logic [15:0] st_xn;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rlfsr_counter #(.WIDTH(16), .FWD_TAPS(16'h100B), .USE_XNOR(1'b0), .SEED(16'h0001)) dut (
        .clk(clk), .rst(rst), .en(en), .up(up), .load(load),
        .load_value(load_value), .state(st)
    );

    rlfsr_counter #(.WIDTH(16), .FWD_TAPS(16'h100B), .USE_XNOR(1'b1), .SEED(16'h0000)) dut_xn (
        .clk(clk), .rst(rst), .en(en), .up(up), .load(load),
        .load_value(load_value), .state(st_xn)
    );

    // Models written from the requirement tap lists
    function automatic logic [15:0] m_fwd(input logic [15:0] s, input logic xn);
        return {s[12] ^ s[3] ^ s[1] ^ s[0] ^ xn, s[15:1]};
    endfunction

    function automatic logic [15:0] m_rev(input logic [15:0] s, input logic xn);
        return {s[14:0], s[15] ^ s[11] ^ s[2] ^ s[0] ^ xn};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, then wait one full cycle
    task automatic cyc(input logic e, input logic u, input logic l, input logic [15:0] v);
        en = e; up = u; load = l; load_value = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 16'h0);
        cyc(1'b0, 1'b1, 1'b0, 16'h0);
        chk("R1 seed xor", st, 16'h0001);
        chk("R1 seed xnor", st_xn, 16'h0000);
        rst = 1'b0;
    endtask

    task automatic t_hold();
        cyc(1'b0, 1'b0, 1'b1, 16'hBEEF);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, i[0], 1'b0, 16'h1111);
            chk("R2 hold", st, 16'hBEEF);
        end
    endtask

    task automatic t_load();
        cyc(1'b1, 1'b0, 1'b1, 16'h5A5A);
        chk("R3 load over rev", st, 16'h5A5A);
        cyc(1'b1, 1'b1, 1'b1, 16'h8001);
        chk("R3 load over fwd", st, 16'h8001);
    endtask

    task automatic t_single_steps();
        logic [15:0] e;
        cyc(1'b0, 1'b0, 1'b1, 16'h1234);
        e = 16'h1234;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 16'h0);
            e = m_fwd(e, 1'b0);
            chk("R4 fwd step", st, e);
        end
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 16'h0);
            e = m_rev(e, 1'b0);
            chk("R5 rev step", st, e);
        end
        chk("R6 back at 1234", st, 16'h1234);
    endtask

    task automatic t_round_trip();
        logic [15:0] vals [4] = '{16'h0001, 16'h8000, 16'hFFFF, 16'h7A3C};
        foreach (vals[k]) begin
            cyc(1'b0, 1'b0, 1'b1, vals[k]);
            cyc(1'b1, 1'b1, 1'b0, 16'h0);
            cyc(1'b1, 1'b0, 1'b0, 16'h0);
            chk("R6 round trip", st, vals[k]);
        end
    endtask

    task automatic t_walk();
        logic [15:0] e;
        int errs = 0;
        cyc(1'b0, 1'b0, 1'b1, 16'hC0DE);
        e = 16'hC0DE;
        for (int i = 0; i < 300; i++) begin
            logic d;
            d = (i % 7 < 4) ^ i[4];
            cyc(1'b1, d, 1'b0, 16'h0);
            e = d ? m_fwd(e, 1'b0) : m_rev(e, 1'b0);
            if (st !== e) errs++;
        end
        chk("R6 mixed walk mismatches", 16'(errs), 16'd0);
    endtask

    task automatic t_fwd_period();
        logic [15:0] e;
        int errs = 0;
        int early = 0;
        cyc(1'b0, 1'b0, 1'b1, 16'h0001);
        e = 16'h0001;
        en = 1'b1; up = 1'b1; load = 1'b0;
        for (int i = 1; i <= 65535; i++) begin
            @(negedge clk);
            e = m_fwd(e, 1'b0);
            if (st !== e) errs++;
            if (i < 65535 && st == 16'h0001) early++;
        end
        chk("R7 fwd mismatches", 16'(errs), 16'd0);
        chk("R7 early return", 16'(early), 16'd0);
        chk("R7 period end", st, 16'h0001);
    endtask

    task automatic t_rev_period();
        logic [15:0] e;
        int errs = 0;
        int early = 0;
        cyc(1'b0, 1'b0, 1'b1, 16'h0001);
        e = 16'h0001;
        en = 1'b1; up = 1'b0; load = 1'b0;
        for (int i = 1; i <= 65535; i++) begin
            @(negedge clk);
            e = m_rev(e, 1'b0);
            if (st !== e) errs++;
            if (i < 65535 && st == 16'h0001) early++;
        end
        chk("R8 rev mismatches", 16'(errs), 16'd0);
        chk("R8 early return", 16'(early), 16'd0);
        chk("R8 period end", st, 16'h0001);
    endtask

    task automatic t_lockup();
        cyc(1'b0, 1'b0, 1'b1, 16'h0000);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        chk("R9 zero stuck fwd", st, 16'h0000);
        cyc(1'b1, 1'b0, 1'b0, 16'h0);
        chk("R9 zero stuck rev", st, 16'h0000);
        cyc(1'b0, 1'b0, 1'b1, 16'h0001);
        cyc(1'b1, 1'b0, 1'b0, 16'h0);
        chk("R9 nonzero predecessor", st, m_rev(16'h0001, 1'b0));
    endtask

    task automatic t_xnor();
        logic [15:0] e;
        cyc(1'b0, 1'b0, 1'b1, 16'h2468);
        e = 16'h2468;
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 16'h0);
            e = m_fwd(e, 1'b1);
            chk("R10 xnor fwd", st_xn, e);
        end
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 16'h0);
            e = m_rev(e, 1'b1);
            chk("R10 xnor rev", st_xn, e);
        end
        cyc(1'b0, 1'b0, 1'b1, 16'hFFFF);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        chk("R10 ones stuck fwd", st_xn, 16'hFFFF);
        cyc(1'b1, 1'b0, 1'b0, 16'h0);
        chk("R10 ones stuck rev", st_xn, 16'hFFFF);
    endtask

    task automatic t_reset_midrun();
        cyc(1'b0, 1'b0, 1'b1, 16'h9999);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        rst = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        chk("R1 reset while stepping", st, 16'h0001);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_hold();
        t_load();
        t_single_steps();
        t_round_trip();
        t_walk();
        t_lockup();
        t_xnor();
        t_reset_midrun();
        t_fwd_period();
        t_rev_period();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule